// File: doc/BRIEF.md
# Serial PHY Management Controller with Address Polling

This block is the management master of a two-wire serial PHY management bus: one clock line it drives and one shared bidirectional data line. It builds 64-bit management frames itself and drives them out on that bus. The clock line is derived from the system clock by a programmable divider. When no host command is waiting, the block steps through PHY addresses 0 to 31 in turn. For each address it reads the basic status register, register 1. From those reads it keeps two 32-bit maps: one of the PHYs that answered and one of the PHYs that report link up.

Host software works through a small register port with single-cycle accesses. There are two user command channels. Each channel can issue one read or write to any register of any PHY. Each channel also names one PHY to watch for link changes. Two interrupt outputs are driven: one for link changes on the watched PHYs and one for completed user commands. Both have a raw and a masked view, and the raw bits are cleared by writing 1.

Top module: `mdio_poll_ctrl`

## Requirements
- R1: After reset, the version word at offset 0x00 reads 0x00010002. The alive map (0x08) and the link map (0x0C) read zero. The management clock is low, the data line is not driven, and both interrupt outputs are low.
- R2: While the enable bit (bit 30 of the control word at 0x04) is clear, no new frame starts. Once any frame in flight has finished, the management clock stays constant and the data line is not driven.
- R3: The management clock changes level every D+1 system clock cycles, where D is the divider field in bits 7:0 of the control word.
- R4: A frame is sent MSB first in this order: 32 ones, then 01, then the opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register address, the turnaround (10 on writes) and 16 data bits. Each bit changes after a falling clock edge. On reads the line is released from the first turnaround bit onward, and the input is sampled on rising edges.
- R5: With no user command pending, successive frames are reads of register 1 at PHY addresses 0, 1, … 31, 0, … in turn.
- R6: Bit a of the alive map is 1 exactly when PHY a pulled the second turnaround bit low on its most recent poll.
- R7: Bit a of the link map equals bit 2 of the data returned by PHY a on its most recent poll. It is 0 when that poll was not acknowledged.
- R8: The user command word of channel c is at 0x80+8c. Its fields are GO bit 31, write bit 30, ACK bit 29, PHY address bits 28:24, register address bits 20:16 and data bits 15:0. Setting GO issues the frame. On completion GO clears, ACK holds the turnaround acknowledge, and on reads the data field holds the returned data (all ones when no PHY answers).
- R9: A pending user command wins over polling at the next frame boundary. When both channels are pending, the channel not granted most recently goes first, and the other follows in the very next frame.
- R10: A host write to a command word whose GO bit is set has no effect.
- R11: The watch word of channel c is at 0x84+8c: PHY address in bits 4:0, interrupt enable in bit 8. When a poll of that PHY changes its link-map bit, bit c of the link raw word (0x10) sets. The masked word (0x14) is raw AND enable, and the link interrupt output is the OR of the masked bits.
- R12: Completion of a command on channel c sets bit c of the user raw word (0x20). Writing 1s to 0x28 sets mask bits and writing 1s to 0x2C clears them; both offsets read the mask. The masked word (0x24) is raw AND mask, and the user interrupt output is the OR of its bits.
- R13: Writing 1 to a bit of the link raw or user raw word clears that bit, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Resolved level of the management data line |
| mdio_o | output | 1 | Data driven onto the line |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| link_irq_o | output | 1 | Link change interrupt (masked) |
| user_irq_o | output | 1 | User command complete interrupt (masked) |

## Verification
The properties assume that the host uses the register port only with single-cycle strobes. They also assume that only the external PHY drives the data line while the block has released it. The bench meets these assumptions: its tasks issue each access as one-cycle pulses, and its PHY model drives only in the turnaround and data window of a read addressed to it. The divider is written only while the block is disabled, or before the first frame, so that a half period is never cut short by a reprogram during counting.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_BIT     = 46;
  localparam int unsigned ACK_BIT    = 47;
  localparam int unsigned DATA_BIT   = 48;
  localparam int unsigned LINK_BIT   = 2;
  localparam logic [4:0]  STATUS_REG = 5'd1;

  typedef struct packed {
    logic        go;
    logic        wr;
    logic        ack;
    logic [4:0]  phy;
    logic [2:0]  rsv;
    logic [4:0]  ra;
    logic [15:0] data;
  } uacc_t;

  localparam logic [7:0] A_VER  = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_ALIV = 8'h08;
  localparam logic [7:0] A_LINK = 8'h0C;
  localparam logic [7:0] A_LRAW = 8'h10;
  localparam logic [7:0] A_LMSK = 8'h14;
  localparam logic [7:0] A_URAW = 8'h20;
  localparam logic [7:0] A_UMSK = 8'h24;
  localparam logic [7:0] A_MSET = 8'h28;
  localparam logic [7:0] A_MCLR = 8'h2C;
  localparam logic [7:0] A_UACC = 8'h80;
  localparam logic [7:0] A_USEL = 8'h84;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  ra_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        ack_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int unsigned PW = $clog2(FRAME_BITS) + 1;

  logic [FRAME_BITS-1:0] sreg_q;
  logic [PW-1:0]         pos_q, cur;
  logic                  busy_q, done_q, wr_q, ack_q, mdio_q, oe_q;
  logic [15:0]           rdata_q;

  assign cur       = pos_q - 1'b1;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      pos_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      mdio_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        pos_q  <= '0;
        wr_q   <= wr_i;
        sreg_q <= {32'hFFFF_FFFF, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, ra_i, 2'b10, wdata_i};
      end else if (busy_q) begin
        // shift out after falling edge
        if (fall_i && pos_q < PW'(FRAME_BITS)) begin
          mdio_q <= sreg_q[FRAME_BITS-1];
          sreg_q <= {sreg_q[FRAME_BITS-2:0], 1'b1};
          oe_q   <= wr_q || (pos_q < PW'(TA_BIT));
          pos_q  <= pos_q + 1'b1;
        end
        // sample on rising edge for the bit presented last
        if (rise_i && pos_q != '0) begin
          if (cur == PW'(ACK_BIT)) ack_q <= ~mdio_i;
          if (cur >= PW'(DATA_BIT)) rdata_q <= {rdata_q[14:0], mdio_i};
          if (cur == PW'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            mdio_q <= 1'b1;
            done_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_poll_ctrl.sv
module mdio_poll_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned DIV_W   = 8,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        link_irq_o,
  output logic        user_irq_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              en_q;
  logic [DIV_W-1:0]  div_q;
  logic [31:0]       alive_q, link_q;
  uacc_t             uacc_q [NUM_CH];
  logic [4:0]        sel_phy_q [NUM_CH];
  logic [NUM_CH-1:0] sel_en_q, link_raw_q, user_raw_q, umask_q, go_vec;
  logic [4:0]        poll_q;
  logic              own_user_q;
  logic [CH_W-1:0]   own_ch_q, rr_q, pick;
  logic              pick_valid, start, wr_en, new_link;
  logic              rise, fall, busy, done, ack;
  logic [15:0]       rdata;
  logic              f_wr;
  logic [4:0]        f_phy, f_ra;
  logic [15:0]       f_wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_go
    assign go_vec[c] = uacc_q[c].go;
  end

  // round-robin: first pending channel at or after rr_q
  always_comb begin
    logic [CH_W-1:0] idx;
    pick_valid = 1'b0;
    pick       = rr_q;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      idx = CH_W'((int'(rr_q) + k) % NUM_CH);
      if (go_vec[idx]) begin
        pick_valid = 1'b1;
        pick       = idx;
      end
    end
  end

  assign start = en_q && !busy && !done;

  always_comb begin
    if (pick_valid) begin
      f_wr    = uacc_q[pick].wr;
      f_phy   = uacc_q[pick].phy;
      f_ra    = uacc_q[pick].ra;
      f_wdata = uacc_q[pick].data;
    end else begin
      f_wr    = 1'b0;
      f_phy   = poll_q;
      f_ra    = STATUS_REG;
      f_wdata = '0;
    end
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q || busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (f_wr),
    .phy_i     (f_phy),
    .ra_i      (f_ra),
    .wdata_i   (f_wdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .ack_o     (ack),
    .rdata_o   (rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assign wr_en    = reg_req_i && reg_we_i;
  assign new_link = ack && rdata[LINK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      div_q      <= '0;
      alive_q    <= '0;
      link_q     <= '0;
      sel_en_q   <= '0;
      link_raw_q <= '0;
      user_raw_q <= '0;
      umask_q    <= '0;
      poll_q     <= '0;
      own_user_q <= 1'b0;
      own_ch_q   <= '0;
      rr_q       <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        uacc_q[c]    <= '0;
        sel_phy_q[c] <= '0;
      end
    end else begin
      if (wr_en) begin
        case (reg_addr_i)
          A_CTRL: begin
            en_q  <= reg_wdata_i[30];
            div_q <= reg_wdata_i[DIV_W-1:0];
          end
          A_LRAW:  link_raw_q <= link_raw_q & ~reg_wdata_i[NUM_CH-1:0];
          A_URAW:  user_raw_q <= user_raw_q & ~reg_wdata_i[NUM_CH-1:0];
          A_MSET:  umask_q    <= umask_q | reg_wdata_i[NUM_CH-1:0];
          A_MCLR:  umask_q    <= umask_q & ~reg_wdata_i[NUM_CH-1:0];
          default: ;
        endcase
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && reg_addr_i == 8'(A_UACC + 8 * c) && !uacc_q[c].go) begin
          uacc_q[c]     <= uacc_t'(reg_wdata_i);
          uacc_q[c].ack <= 1'b0;
          uacc_q[c].rsv <= '0;
        end
        if (wr_en && reg_addr_i == 8'(A_USEL + 8 * c)) begin
          sel_phy_q[c] <= reg_wdata_i[4:0];
          sel_en_q[c]  <= reg_wdata_i[8];
        end
      end
      if (start) begin
        own_user_q <= pick_valid;
        own_ch_q   <= pick;
        if (pick_valid) rr_q <= CH_W'((int'(pick) + 1) % NUM_CH);
      end
      // completion updates win over same-cycle host clears
      if (done) begin
        if (!own_user_q) begin
          alive_q[poll_q] <= ack;
          link_q[poll_q]  <= new_link;
          poll_q          <= poll_q + 1'b1;
          for (int c = 0; c < NUM_CH; c++) begin
            if (sel_phy_q[c] == poll_q && link_q[poll_q] != new_link) link_raw_q[c] <= 1'b1;
          end
        end else begin
          uacc_q[own_ch_q].go  <= 1'b0;
          uacc_q[own_ch_q].ack <= ack;
          if (!uacc_q[own_ch_q].wr) uacc_q[own_ch_q].data <= rdata;
          user_raw_q[own_ch_q] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_VER:          reg_rdata_o = VERSION;
      A_CTRL:         reg_rdata_o = {1'b0, en_q, {(30 - DIV_W){1'b0}}, div_q};
      A_ALIV:         reg_rdata_o = alive_q;
      A_LINK:         reg_rdata_o = link_q;
      A_LRAW:         reg_rdata_o = 32'(link_raw_q);
      A_LMSK:         reg_rdata_o = 32'(link_raw_q & sel_en_q);
      A_URAW:         reg_rdata_o = 32'(user_raw_q);
      A_UMSK:         reg_rdata_o = 32'(user_raw_q & umask_q);
      A_MSET, A_MCLR: reg_rdata_o = 32'(umask_q);
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr_i == 8'(A_UACC + 8 * c)) reg_rdata_o = uacc_q[c];
      if (reg_addr_i == 8'(A_USEL + 8 * c)) reg_rdata_o = {23'd0, sel_en_q[c], 3'd0, sel_phy_q[c]};
    end
  end

  assign link_irq_o = |(link_raw_q & sel_en_q);
  assign user_irq_o = |(user_raw_q & umask_q);
endmodule

// File: rtl/mdio_poll_ctrl_chk.sv
module mdio_poll_ctrl_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              own_user_i,
  input logic [CH_W-1:0]   own_ch_i,
  input logic [NUM_CH-1:0] go_i,
  input logic [NUM_CH-1:0] user_raw_i,
  input logic [4:0]        poll_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              mdc_i,
  input logic              oe_i,
  input logic              user_irq_i
);
  AST_MDC_HALF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != '0 && mdc_i != $past(mdc_i)) |=> $stable(mdc_i)); // R3

  AST_MDC_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_i) |=> $stable(mdc_i)); // R2

  AST_OE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> busy_i); // R4

  AST_POLL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !own_user_i) |=> poll_i == $past(poll_i) + 5'd1); // R5

  AST_UIRQ_HAS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_irq_i |-> (user_raw_i != '0)); // R12

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_GO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && own_user_i && int'(own_ch_i) == c) |=> !go_i[c]); // R8

    AST_GO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_i[c] && !(done_i && own_user_i && int'(own_ch_i) == c)) |=> go_i[c]); // R10

    AST_URAW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && own_user_i && int'(own_ch_i) == c) |=> user_raw_i[c]); // R12
  end
endmodule

bind mdio_poll_ctrl mdio_poll_ctrl_chk #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_q),
  .busy_i     (busy),
  .done_i     (done),
  .own_user_i (own_user_q),
  .own_ch_i   (own_ch_q),
  .go_i       (go_vec),
  .user_raw_i (user_raw_q),
  .poll_i     (poll_q),
  .div_i      (div_q),
  .mdc_i      (mdc_o),
  .oe_i       (mdio_oe_o),
  .user_irq_i (user_irq_o)
);

// File: tb/mdio_poll_ctrl_tb_top.sv
module mdio_poll_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_in, mdio_out, mdio_oe, link_irq, user_irq;
  logic        phy_oe = 1'b0, phy_d = 1'b1;
  logic        bus;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign bus     = mdio_oe ? mdio_out : (phy_oe ? phy_d : 1'b1);
  assign mdio_in = bus;

  mdio_poll_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .link_irq_o(link_irq), .user_irq_o(user_irq)
  );

  // ---------------- PHY model ----------------
  logic [15:0] phy_mem [0:31][0:31];
  logic        present [0:31];
  int          poll_seen [0:31];
  int          frame_cnt = 0, ulog_n = 0;
  logic [11:0] ulog_hdr [0:15];
  int          ulog_fr  [0:15];
  int          st = 0, ones = 0, cnt = 0, k = 0;
  logic [11:0] hdr = '0;
  logic [15:0] wd = '0;
  logic        rd_op = 1'b0, oe_bad = 1'b0;
  logic [4:0]  mp = '0, mr = '0;

  initial begin
    for (int a = 0; a < 32; a++) begin
      present[a]   = 1'b0;
      poll_seen[a] = 0;
      for (int r = 0; r < 32; r++) phy_mem[a][r] = 16'h0000;
    end
    present[3]  = 1'b1;
    present[17] = 1'b1;
    phy_mem[3][1] = 16'h0004;
  end

  always @(posedge mdc) begin
    case (st)
      0: if (bus) begin
           if (ones < 40) ones++;
         end else begin
           st = (ones >= 32) ? 1 : 0;
           ones = 0;
         end
      1: if (bus) begin st = 2; cnt = 0; hdr = '0; frame_cnt++; end
         else st = 0;
      2: begin
           hdr = {hdr[10:0], bus};
           cnt++;
           if (cnt == 12) begin
             st = 3; cnt = 0; k = 0;
             rd_op = (hdr[11:10] == 2'b10);
             mp = hdr[9:5];
             mr = hdr[4:0];
             if (rd_op && mr == 5'd1) poll_seen[mp]++;
             else if (ulog_n < 16) begin
               ulog_hdr[ulog_n] = hdr;
               ulog_fr[ulog_n]  = frame_cnt;
               ulog_n++;
             end
           end
         end
      default: begin
           if (cnt == 0 && rd_op && mdio_oe) oe_bad = 1'b1;
           if (cnt >= 2) wd = {wd[14:0], bus};
           cnt++;
           if (cnt == 18) begin
             if (!rd_op) phy_mem[mp][mr] = wd;
             st = 0;
           end
         end
    endcase
  end

  always @(negedge mdc) begin
    if (st == 3 && rd_op && present[mp]) begin
      if (k == 0) phy_oe = 1'b0;
      else if (k == 1) begin phy_oe = 1'b1; phy_d = 1'b0; end
      else if (k < 18) begin phy_oe = 1'b1; phy_d = phy_mem[mp][mr][17-k]; end
      else phy_oe = 1'b0;
      k++;
    end else phy_oe = 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_go(input int ch);
    logic [31:0] v;
    int guard = 0;
    do begin
      reg_rd(8'(8'h80 + 8 * ch), v);
      guard++;
    end while (v[31] && guard < 5000);
  endtask

  function automatic logic [31:0] cmd(input logic go, wr, input logic [4:0] p, r, input logic [15:0] d);
    return {go, wr, 1'b0, p, 3'b000, r, d};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    reg_rd(8'h00, v); chk("R1", "version", v, 32'h0001_0002);
    reg_rd(8'h08, v); chk("R1", "alive", v, 32'h0);
    reg_rd(8'h0C, v); chk("R1", "link", v, 32'h0);
    chk("R1", "pins mdc/oe/irqs", {28'd0, mdc, mdio_oe, link_irq, user_irq}, 32'h0);
  endtask

  task automatic t_disabled();
    int tog = 0, drv = 0;
    logic last;
    reg_wr(8'h04, 32'h0000_0001);
    last = mdc;
    repeat (100) begin
      @(negedge clk);
      if (mdc != last) tog++;
      if (mdio_oe) drv++;
      last = mdc;
    end
    chk("R2", "mdc toggles while disabled", tog, 0);
    chk("R2", "drive while disabled", drv, 0);
  endtask

  task automatic t_divider();
    time t1, t2;
    reg_wr(8'h04, 32'h4000_0001);
    @(posedge mdc); t1 = $time;
    @(negedge mdc); t2 = $time;
    chk("R3", "half period cycles (D=1)", 32'((t2 - t1) / 8), 32'd2);
  endtask

  task automatic t_poll();
    logic [31:0] v;
    int missing = 0;
    repeat (18000) @(negedge clk);
    for (int a = 0; a < 32; a++) if (poll_seen[a] < 1) missing++;
    chk("R5", "addresses never polled", missing, 0);
    chk("R5", "no user frames during polling", ulog_n, 0);
    reg_rd(8'h08, v); chk("R6", "alive map", v, 32'h0002_0008);
    reg_rd(8'h0C, v); chk("R7", "link map", v, 32'h0000_0008);
  endtask

  task automatic t_link_irq();
    logic [31:0] v;
    reg_wr(8'h84, 32'h0000_0103);
    reg_wr(8'h8C, 32'h0000_0011);
    reg_wr(8'h10, 32'h3);
    phy_mem[3][1]  = 16'h0000;
    phy_mem[17][1] = 16'h0004;
    repeat (18000) @(negedge clk);
    reg_rd(8'h0C, v); chk("R7", "link map after change", v, 32'h0002_0000);
    reg_rd(8'h10, v); chk("R11", "link raw", v, 32'h3);
    reg_rd(8'h14, v); chk("R11", "link masked", v, 32'h1);
    chk("R11", "link irq pin", link_irq, 1'b1);
    reg_wr(8'h10, 32'h1);
    reg_rd(8'h10, v); chk("R13", "link raw after W1C bit0", v, 32'h2);
    chk("R13", "link irq after clear", link_irq, 1'b0);
    reg_wr(8'h10, 32'h0);
    reg_rd(8'h10, v); chk("R13", "link raw after write 0", v, 32'h2);
    reg_wr(8'h10, 32'h2);
  endtask

  task automatic t_user_write();
    logic [31:0] v;
    reg_wr(8'h28, 32'h1);
    reg_wr(8'h80, cmd(1'b1, 1'b1, 5'd3, 5'd5, 16'hA5C3));
    wait_go(0);
    chk("R4", "phy register written", 32'(phy_mem[3][5]), 32'h0000_A5C3);
    chk("R4", "write header op/phy/reg", 32'(ulog_hdr[ulog_n-1]), 32'({2'b01, 5'd3, 5'd5}));
    reg_rd(8'h20, v); chk("R12", "user raw ch0", v, 32'h1);
    reg_rd(8'h24, v); chk("R12", "user masked ch0", v, 32'h1);
    chk("R12", "user irq pin", user_irq, 1'b1);
    reg_rd(8'h2C, v); chk("R12", "mask readback", v, 32'h1);
  endtask

  task automatic t_user_read();
    logic [31:0] v;
    reg_wr(8'h88, cmd(1'b1, 1'b0, 5'd3, 5'd5, 16'h0));
    wait_go(1);
    reg_rd(8'h88, v); chk("R8", "read result word", v, {3'b001, 5'd3, 3'b000, 5'd5, 16'hA5C3});
    chk("R4", "line released in turnaround", oe_bad, 1'b0);
    reg_rd(8'h20, v); chk("R12", "user raw both", v, 32'h3);
    reg_rd(8'h24, v); chk("R12", "user masked ch1 off", v, 32'h1);
    reg_wr(8'h20, 32'h3);
    reg_rd(8'h20, v); chk("R13", "user raw cleared", v, 32'h0);
    chk("R13", "user irq after clear", user_irq, 1'b0);
    reg_wr(8'h88, cmd(1'b1, 1'b0, 5'd9, 5'd2, 16'h0));
    wait_go(1);
    reg_rd(8'h88, v); chk("R8", "absent phy no ack", v, {3'b000, 5'd9, 3'b000, 5'd2, 16'hFFFF});
    reg_wr(8'h2C, 32'h1);
    reg_rd(8'h28, v); chk("R12", "mask cleared", v, 32'h0);
    reg_wr(8'h20, 32'h3);
  endtask

  task automatic t_busy_write();
    logic [31:0] v;
    reg_wr(8'h80, cmd(1'b1, 1'b0, 5'd3, 5'd5, 16'h0));
    reg_wr(8'h80, cmd(1'b1, 1'b1, 5'd17, 5'd2, 16'h1234));
    wait_go(0);
    reg_rd(8'h80, v); chk("R10", "word kept while GO", v, {3'b001, 5'd3, 3'b000, 5'd5, 16'hA5C3});
    chk("R10", "ignored write not issued", 32'(phy_mem[17][2]), 32'h0);
  endtask

  task automatic t_rr();
    int n, f;
    reg_wr(8'h04, 32'h0000_0001);
    repeat (400) @(negedge clk);
    chk("R2", "no drive after disable", mdio_oe, 1'b0);
    n = ulog_n; f = frame_cnt;
    reg_wr(8'h80, cmd(1'b1, 1'b0, 5'd3, 5'd7, 16'h0));
    reg_wr(8'h88, cmd(1'b1, 1'b0, 5'd3, 5'd8, 16'h0));
    reg_wr(8'h04, 32'h4000_0001);
    wait_go(0);
    wait_go(1);
    chk("R9", "two user frames", ulog_n - n, 2);
    chk("R9", "ch1 first (last grant ch0)", 32'(ulog_hdr[n][4:0]), 32'd8);
    chk("R9", "ch0 second", 32'(ulog_hdr[n+1][4:0]), 32'd7);
    chk("R9", "first user frame slot", ulog_fr[n] - f, 1);
    chk("R9", "second user frame slot", ulog_fr[n+1] - f, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_divider();
    t_poll();
    t_link_irq();
    t_user_write();
    t_user_read();
    t_busy_write();
    t_rr();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule